// File: doc/BRIEF.md
# Selectable Edge Trigger Router

This block chooses one line out of a bank of ten programmable function inputs and uses it as the start trigger for an acquisition sequencer. Each line passes through a two-flop synchronizer. A configuration bit chooses whether a rising or a falling transition on the selected line counts. When the chosen transition is seen, the block raises a start event for exactly one cycle. The sequencer uses that event the same way for pretriggered and posttriggered runs.

Each start event also regenerates an active-high pulse of fixed length on a dedicated trigger-out pin. The pulse mirrors whichever source line actually fired. With the intended 20 MHz clock the default length of 2 cycles gives 100 ns. The integrator must keep the pulse length inside the 50 to 100 ns window. Whether the pin is driven is set by an output-enable bit, which the block registers. After reset the pin is left undriven.

Top module: `start_trig_router`

## Requirements
- R1: While reset is low and in the first cycle after it, `start_evt`, `trig_out` and `trig_oe` are all 0.
- R2: `src_sel` values 0 to 9 pick the line `fn_lines[src_sel]`. Transitions on every other line have no effect on `start_evt` or `trig_out`.
- R3: When `fall_sel` is 0, only a 0-to-1 transition of the selected line makes an event. When `fall_sel` is 1, only a 1-to-0 transition does.
- R4: A qualifying transition that is applied to `fn_lines` just after clock edge k shows as `start_evt` = 1 between edges k+2 and k+3. This delay comes from the two synchronizer stages. The event is high for exactly one cycle.
- R5: A start event that finds no pulse active sets `trig_out` high for PULSE_CYC cycles (default 2), starting at the next clock edge.
- R6: If a start event arrives while `trig_out` is high, `start_evt` is still raised, but the pulse is neither restarted nor lengthened.
- R7: In a cycle where `src_sel` or `fall_sel` differs from its value at the previous clock edge, no event is produced. After that cycle, edge history is taken from the newly selected line.
- R8: When `src_sel` is 10 or above, no start events are produced.
- R9: `trig_oe` equals the `drv_en` value that was present at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 4 | Index of the trigger source line; 10 and above disables triggering |
| fall_sel | input | 1 | 0 = rising transition, 1 = falling transition |
| drv_en | input | 1 | Request to drive the trigger-out pin |
| fn_lines | input | 10 | Asynchronous programmable function input lines |
| start_evt | output | 1 | One-cycle start event to the sequencer |
| trig_out | output | 1 | Regenerated trigger pulse data |
| trig_oe | output | 1 | Output enable for the trigger-out pin |

## Verification
The bench checks the following corner cases:

- **Configuration switch between lines at different levels.** A design that compared against history from the old line would raise a false event.
- **Second edge during a live pulse.** A design that reloads its counter would stretch the output.
- **Out-of-range select values.** A design that indexes without a guard would fire on some arbitrary line.
- **Wrong polarity and non-selected lines.** Toggling these must stay silent.
- **Constrained random mix.** Lines, select, polarity and enable change at random. Every cycle is compared with a cycle-exact expectation, so one cycle of extra or missing synchronizer delay shows up at once.

// File: rtl/trig_pkg.sv
// Shared definitions for the trigger router.
package trig_pkg;
    // Which transition of the selected line counts as a trigger.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_pol_e;
endpackage

// File: rtl/line_sync.sv
// Multi-stage synchronizer for a bank of asynchronous input lines.
// Assumes: each line is quasi-static relative to clk; the reset value is 0.
module line_sync #(
    parameter int unsigned WIDTH  = 10,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift one synchronizer stage per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= d_async;
                else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/edge_pick.sv
// Selects one synchronized line, keeps one cycle of history and flags the
// chosen transition. Assumes the inputs are already synchronized. A change
// of configuration suppresses detection for one cycle while history reloads.
module edge_pick
    import trig_pkg::*;
#(
    parameter int unsigned N_LINES = 10,
    parameter int unsigned SEL_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lines,
    input  logic [SEL_W-1:0]   sel,
    input  edge_pol_e          pol,
    output logic               evt
);
    localparam int unsigned CFG_W = SEL_W + 1;

    logic             sel_ok;
    logic             cur;
    logic             hist_q;
    logic [CFG_W-1:0] cfg_now;
    logic [CFG_W-1:0] cfg_q;
    logic             cfg_moved;

    assign sel_ok    = ({1'b0, sel} < CFG_W'(N_LINES));
    assign cfg_now   = {sel, pol};
    assign cfg_moved = (cfg_now != cfg_q);

    // Route the selected line; an invalid selection reads as a quiet 0.
    always_comb begin
        cur = 1'b0;
        for (int i = 0; i < N_LINES; i++) begin
            if (sel_ok && sel == SEL_W'(i)) cur = lines[i];
        end
    end

    // Keep the previous selected value and the configuration it belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= 1'b0;
            cfg_q  <= '0;
        end else begin
            hist_q <= cur;
            cfg_q  <= cfg_now;
        end
    end

    // Flag the chosen transition on a stable configuration.
    always_comb begin
        evt = 1'b0;
        if (sel_ok && !cfg_moved && (cur != hist_q))
            evt = (pol == EDGE_RISE) ? cur : hist_q;
    end

    // R4: the event never lasts two cycles.
    a_r4_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);
endmodule

// File: rtl/pulse_gen.sv
// Fixed-length pulse generator. It starts on a request only while idle, so
// requests during a live pulse are dropped. Assumes PULSE_CYC >= 1.
module pulse_gen #(
    parameter int unsigned PULSE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);
    localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);

    logic [CNT_W-1:0] left_q;
    logic [CNT_W-1:0] run_q;

    // Load the counter when idle, otherwise count it down.
    always_ff @(posedge clk) begin
        if (!rst_n) left_q <= '0;
        else if (fire && left_q == '0) left_q <= CNT_W'(PULSE_CYC);
        else if (left_q != '0) left_q <= left_q - 1'b1;
    end

    assign pulse = (left_q != '0);

    // Checker-only: length of the current high run of the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else if (pulse && run_q != CNT_W'(PULSE_CYC)) run_q <= run_q + 1'b1;
        else if (!pulse) run_q <= '0;
    end

    // R5: a request while idle raises the pulse at the next edge.
    a_r5_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !pulse) |=> pulse);
    // R6: the pulse is never longer than PULSE_CYC cycles.
    a_r6_width_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == CNT_W'(PULSE_CYC)) |-> !pulse);
endmodule

// File: rtl/start_trig_router.sv
// Trigger router top: synchronizes the function lines, detects the chosen
// edge on the selected line, emits a start event, regenerates a fixed pulse
// and registers the output enable. Assumes the lines are low during reset.
module start_trig_router
    import trig_pkg::*;
#(
    parameter int unsigned N_LINES     = 10,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PULSE_CYC   = 2,
    parameter int unsigned SEL_W       = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic               fall_sel,
    input  logic               drv_en,
    input  logic [N_LINES-1:0] fn_lines,
    output logic               start_evt,
    output logic               trig_out,
    output logic               trig_oe
);
    logic [N_LINES-1:0] lines_s;
    edge_pol_e          pol;
    logic               oe_q;

    assign pol = edge_pol_e'(fall_sel);

    line_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(fn_lines), .d_sync(lines_s));

    edge_pick #(.N_LINES(N_LINES), .SEL_W(SEL_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .lines(lines_s), .sel(src_sel),
        .pol(pol), .evt(start_evt));

    pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk(clk), .rst_n(rst_n), .fire(start_evt), .pulse(trig_out));

    // Register the pin enable; it stays off from reset until requested.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_q <= 1'b0;
        else oe_q <= drv_en;
    end

    assign trig_oe = oe_q;

    // R9: the enable follows the request one cycle later.
    a_r9_oe_follow: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (trig_oe == $past(drv_en)));
    // R8: an out-of-range source that is held steady never fires.
    a_r8_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, src_sel} >= (SEL_W+1)'(N_LINES)) |-> !start_evt);
endmodule

// File: tb/tb_start_trig_router.sv
// Self-checking bench: directed corner cases plus seeded random stimulus,
// compared each cycle against a model built from the requirements.
module tb_start_trig_router;
    localparam int N = 10;
    localparam int P = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_sel = 4'd0;
    logic       fall_sel = 1'b0;
    logic       drv_en = 1'b0;
    logic [N-1:0] fn_lines = '0;
    logic       start_evt, trig_out, trig_oe;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string tag = "R2";

    start_trig_router dut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .fall_sel(fall_sel),
        .drv_en(drv_en), .fn_lines(fn_lines), .start_evt(start_evt),
        .trig_out(trig_out), .trig_oe(trig_oe));

    always #10 clk = ~clk;

    // Model state: line history two and three edges back, previous config.
    logic [N-1:0] h1, h2, h3;
    logic [3:0]   sel1;
    logic         pol1;
    int           left;
    logic         oe_exp;
    logic         exp_evt;

    // Expected event from R2, R3, R4, R7 and R8.
    function automatic logic f_evt(input logic [3:0] s, input logic p,
                                   input logic [3:0] s1, input logic p1,
                                   input logic [N-1:0] now, input logic [N-1:0] old);
        if (s >= 4'(N)) return 1'b0;
        if (s != s1 || p != p1) return 1'b0;
        return p ? (old[s] & ~now[s]) : (now[s] & ~old[s]);
    endfunction

    assign exp_evt = f_evt(src_sel, fall_sel, sel1, pol1, h2, h3);

    always @(posedge clk) begin
        if (!rst_n) begin
            h1 <= '0; h2 <= '0; h3 <= '0; sel1 <= '0; pol1 <= 1'b0;
            left <= 0; oe_exp <= 1'b0;
        end else begin
            h1 <= fn_lines; h2 <= h1; h3 <= h2;
            sel1 <= src_sel; pol1 <= fall_sel;
            if (exp_evt && left == 0) left <= P;
            else if (left != 0) left <= left - 1;
            oe_exp <= drv_en;
        end
    end

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0b expected %0b (cycle %0d)", req, what, got, exp, cyc);
        end
    endtask

    // One cycle: check outputs at the falling edge, then drive new inputs.
    task automatic step(input logic [N-1:0] l, input logic [3:0] s, input logic p, input logic e);
        @(negedge clk);
        chk(tag, "start_evt", start_evt, exp_evt);
        chk((tag == "R6") ? "R6" : "R5", "trig_out", trig_out, left != 0);
        chk("R9", "trig_oe", trig_oe, oe_exp);
        fn_lines = l; src_sel = s; fall_sel = p; drv_en = e;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset values.
        chk("R1", "start_evt", start_evt, 1'b0);
        chk("R1", "trig_out", trig_out, 1'b0);
        chk("R1", "trig_oe", trig_oe, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "trig_oe after reset", trig_oe, 1'b0);
        chk("R1", "trig_out after reset", trig_out, 1'b0);

        // R2, R4: line 5 rises, others toggle quietly.
        tag = "R2";
        step('0, 4'd5, 1'b0, 1'b1);
        step(10'b0000000011, 4'd5, 1'b0, 1'b1);
        step(10'b0000100011, 4'd5, 1'b0, 1'b1);
        tag = "R4";
        step(10'b0000100011, 4'd5, 1'b0, 1'b1);
        step(10'b0000100011, 4'd5, 1'b0, 1'b1);
        // Directed R4 timing: event two falling edges after the change.
        @(negedge clk);
        chk("R4", "no event without change", start_evt, 1'b0);
        fn_lines[5] = 1'b0;
        fall_sel = 1'b0; // falling edge ignored under rising polarity (R3)
        repeat (4) step(fn_lines, 4'd5, 1'b0, 1'b1);
        fn_lines[5] = 1'b1;
        @(negedge clk);
        chk("R4", "evt one edge later", start_evt, 1'b0);
        @(negedge clk);
        chk("R4", "evt two edges later", start_evt, 1'b1);
        @(negedge clk);
        chk("R4", "evt single cycle", start_evt, 1'b0);
        chk("R5", "pulse first cycle", trig_out, 1'b1);
        @(negedge clk);
        chk("R5", "pulse second cycle", trig_out, 1'b1);
        @(negedge clk);
        chk("R5", "pulse ended", trig_out, 1'b0);

        // R3: falling polarity on line 5.
        tag = "R3";
        repeat (3) step(10'b0000100000, 4'd5, 1'b1, 1'b0);
        repeat (4) step(10'b0000000000, 4'd5, 1'b1, 1'b0);
        repeat (4) step(10'b0000100000, 4'd5, 1'b1, 1'b0);

        // R6: second rising edge while the pulse is live.
        tag = "R6";
        repeat (3) step(10'b0000000000, 4'd2, 1'b0, 1'b1);
        step(10'b0000000100, 4'd2, 1'b0, 1'b1);
        step(10'b0000000000, 4'd2, 1'b0, 1'b1);
        step(10'b0000000100, 4'd2, 1'b0, 1'b1);
        repeat (6) step(10'b0000000100, 4'd2, 1'b0, 1'b1);

        // R7: switch from a high line to a low one and back, levels steady.
        tag = "R7";
        repeat (4) step(10'b0000001000, 4'd3, 1'b0, 1'b1);
        repeat (4) step(10'b0000001000, 4'd4, 1'b1, 1'b1);
        repeat (4) step(10'b0000001000, 4'd3, 1'b0, 1'b1);
        repeat (4) step(10'b0000001000, 4'd3, 1'b1, 1'b1);

        // R8: out-of-range selects with all lines toggling.
        tag = "R8";
        for (int k = 0; k < 12; k++)
            step((k % 2 == 0) ? '1 : '0, 4'(10 + (k % 6)), k[0], 1'b0);

        // Random mix; the tag follows the current select range.
        for (int k = 0; k < 4000; k++) begin
            logic [N-1:0] l;
            logic [3:0]   s;
            logic         p;
            l = fn_lines;
            if ($urandom_range(0, 2) == 0) l[$urandom_range(0, N-1)] ^= 1'b1;
            s = src_sel;
            p = fall_sel;
            if ($urandom_range(0, 29) == 0) s = 4'($urandom_range(0, 13));
            if ($urandom_range(0, 39) == 0) p = ~p;
            tag = (src_sel >= 4'(N)) ? "R8" : "R2";
            step(l, s, p, 1'($urandom_range(0, 1)));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule